// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Receive Queue

This block takes one asynchronous serial input line and turns the characters arriving on it into bytes in a 16-entry queue. A clock enable at sixteen times the bit rate drives all line sampling. The receiver notices a high-to-low transition and checks half a bit later that the line is still low. It then takes each data bit at its centre, least significant bit first. It can take a parity bit, even or odd, followed by one or two stop bits.

At the end of every frame the receiver decides whether the character goes into the queue. It checks the stop bit, whether the queue has room and whether a break is pending. Any error halts the receiver until software clears the status flags. Four status flags are kept: queue-above-trigger, idle timeout, error and break. Each flag is cleared by reading it as 1 and then writing 0 to its bit. Three interrupt requests follow these flags, and one shared enable gates all three.

Top module: `uart_rx_fifo`

## Requirements
- R1: A frame starts only on a high-to-low change of the line while idle, confirmed low 8 oversample ticks later; a low pulse shorter than that is ignored and produces no character and no flag.
- R2: Data bits are taken at bit centres (16 ticks apart), first received bit into bit 0; the oldest stored character is shown on `rd_data`.
- R3: With `cfg_par_en`=1 a parity bit follows the data; `cfg_par_odd`=0 expects an even total of ones over data and parity, 1 expects odd. A mismatch sets the error flag and the character is still stored.
- R4: A first stop bit sampled as 0 sets the error flag and the character is discarded; with `cfg_two_stop`=1 the second stop bit is not checked and a 0 there causes neither an error nor a false start.
- R5: A frame whose data, parity and first stop samples are all 0 is a break: the break flag (`stat_flags[2]`) and the error flag (`stat_flags[3]`) are set and nothing is stored.
- R6: A good character that arrives while the queue holds 16 entries is dropped, the error flag is set, and the queue contents are unchanged.
- R7: While the error or break flag is set no new frame is received.
- R8: The full flag (`stat_flags[1]`) is set in every cycle in which `rx_count` >= `cfg_trig` (trigger range 1 to 16), so it cannot be cleared while the count stays at or above the trigger.
- R9: The ready flag (`stat_flags[0]`) is set once the count is nonzero and below `cfg_trig` and 24 ticks per frame bit have passed with no write and no pop (240 ticks for 8 data bits, no parity, one stop).
- R10: A `stat_wr` clears a flag only where the bit written is 0 and that flag was seen as 1 at the last `stat_rd`; a write without the earlier read leaves it set.
- R11: `irq_rx` = `rie` and (full or ready), `irq_err` = `rie` and error, `irq_brk` = `rie` and break; with `rie`=0 all three are low.
- R12: After reset all flags, interrupts and `rx_count` are 0; a `rd_en` pulse on a non-empty queue removes the oldest entry and lowers `rx_count` by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick16 | input | 1 | Oversample enable, 16 per bit time |
| rxd | input | 1 | Serial input line, idle high |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | Two stop bits per frame |
| cfg_trig | input | 5 | Queue level that sets the full flag |
| rie | input | 1 | Shared interrupt enable |
| rd_en | input | 1 | Pop the oldest character |
| rd_data | output | 8 | Oldest character in the queue |
| rx_count | output | 5 | Number of stored characters |
| stat_rd | input | 1 | Status read strobe, arms flags seen as 1 |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 4 | Write data; 0 clears an armed flag |
| stat_flags | output | 4 | {error, break, full, ready} |
| irq_rx | output | 1 | Receive-data interrupt request |
| irq_err | output | 1 | Error interrupt request |
| irq_brk | output | 1 | Break interrupt request |

## Verification
The checks assume that `cfg_trig`, parity and stop settings change only while reset is held, and that `rd_en`, `stat_rd` and `stat_wr` are single-cycle pulses. The bench meets this by setting the configuration inside its reset task and by issuing every strobe for one cycle at a falling edge. The line is driven in whole bit times of 16 enable ticks, with the enable high every other clock. This keeps the centre sampling well clear of bit edges, except where a test shortens a pulse on purpose.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_STOP2} rx_state_e;

  localparam int FL_READY = 0;
  localparam int FL_FULL  = 1;
  localparam int FL_BRK   = 2;
  localparam int FL_ERR   = 3;
  localparam int NFLAGS   = 4;

  // bits per frame including start, parity and stop bits
  function automatic int unsigned frame_bits(input int unsigned dw, input logic par_en,
                                             input logic two_stop);
    return 1 + dw + (par_en ? 1 : 0) + (two_stop ? 2 : 1);
  endfunction

  // idle timeout: one and a half frames of 16 ticks per bit
  function automatic int unsigned timeout_ticks(input int unsigned dw, input logic par_en,
                                                input logic two_stop);
    return frame_bits(dw, par_en, two_stop) * 24;
  endfunction

  function automatic logic parity_bad(input logic data_xor, input logic par_bit, input logic odd);
    return (data_xor ^ par_bit) != odd;
  endfunction
endpackage

// File: rtl/urx_frame.sv
module urx_frame import urx_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic              halt,
  output logic              ev_done,
  output logic [DATA_W-1:0] ev_data,
  output logic              ev_fer,
  output logic              ev_per,
  output logic              ev_brk
);
  localparam int BI_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BI_W-1:0] LAST = BI_W'(DATA_W - 1);

  rx_state_e         state;
  logic [1:0]        sync;
  logic              rx_s, prev, allz, parbit;
  logic [3:0]        tcnt;
  logic [BI_W-1:0]   bidx;
  logic [DATA_W-1:0] sreg;
  logic              centre;

  assign rx_s   = sync[1];
  assign centre = (tcnt == 4'd15);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync    <= 2'b11;
      state   <= S_IDLE;
      prev    <= 1'b1;
      tcnt    <= '0;
      bidx    <= '0;
      sreg    <= '0;
      allz    <= 1'b0;
      parbit  <= 1'b0;
      ev_done <= 1'b0;
      ev_data <= '0;
      ev_fer  <= 1'b0;
      ev_per  <= 1'b0;
      ev_brk  <= 1'b0;
    end else begin
      sync    <= {sync[0], rxd};
      ev_done <= 1'b0;
      if (tick) begin
        prev <= rx_s;
        tcnt <= tcnt + 4'd1;
        case (state)
          S_IDLE: if (!halt && prev && !rx_s) begin
            state <= S_START;
            tcnt  <= '0;
          end
          S_START: if (tcnt == 4'd7) begin
            tcnt <= '0;
            bidx <= '0;
            allz <= 1'b1;
            state <= rx_s ? S_IDLE : S_DATA;
          end
          S_DATA: if (centre) begin
            sreg <= {rx_s, sreg[DATA_W-1:1]};
            allz <= allz & ~rx_s;
            if (bidx == LAST) state <= par_en ? S_PAR : S_STOP;
            else bidx <= bidx + 1'b1;
          end
          S_PAR: if (centre) begin
            parbit <= rx_s;
            allz   <= allz & ~rx_s;
            state  <= S_STOP;
          end
          S_STOP: if (centre) begin
            ev_done <= 1'b1;
            ev_data <= sreg;
            ev_fer  <= ~rx_s;
            ev_brk  <= allz & ~rx_s;
            ev_per  <= par_en & parity_bad(^sreg, parbit, par_odd);
            state   <= two_stop ? S_STOP2 : S_IDLE;
          end
          S_STOP2: if (centre) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [W-1:0]               wdata,
  input  logic                       rd,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == TOP) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr) wptr <= bump(wptr);
      if (rd) rptr <= bump(rptr);
      case ({wr, rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo import urx_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick16,
  input  logic                       rxd,
  input  logic                       cfg_par_en,
  input  logic                       cfg_par_odd,
  input  logic                       cfg_two_stop,
  input  logic [$clog2(DEPTH+1)-1:0] cfg_trig,
  input  logic                       rie,
  input  logic                       rd_en,
  output logic [DATA_W-1:0]          rd_data,
  output logic [$clog2(DEPTH+1)-1:0] rx_count,
  input  logic                       stat_rd,
  input  logic                       stat_wr,
  input  logic [NFLAGS-1:0]          stat_wdata,
  output logic [NFLAGS-1:0]          stat_flags,
  output logic                       irq_rx,
  output logic                       irq_err,
  output logic                       irq_brk
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int TO_W  = $clog2(24 * (DATA_W + 4) + 1);

  logic              ev_done, ev_fer, ev_per, ev_brk;
  logic [DATA_W-1:0] ev_data;
  logic              fifo_wr, fifo_pop, fifo_full, fifo_empty, overrun;
  logic [NFLAGS-1:0] flags, armed, set_v, clr_v;
  logic [TO_W-1:0]   to_cnt, to_lim;
  logic              to_run, to_fire;

  urx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .two_stop(cfg_two_stop),
    .halt(flags[FL_ERR] | flags[FL_BRK]),
    .ev_done(ev_done), .ev_data(ev_data), .ev_fer(ev_fer), .ev_per(ev_per), .ev_brk(ev_brk)
  );

  // a character is kept only if the stop bit is good, there is room and no break is pending
  assign fifo_wr  = ev_done & ~ev_fer & ~fifo_full & ~flags[FL_BRK];
  assign overrun  = ev_done & ~ev_fer & fifo_full;
  assign fifo_pop = rd_en & ~fifo_empty;

  urx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr(fifo_wr), .wdata(ev_data), .rd(fifo_pop),
    .rdata(rd_data), .count(rx_count), .full(fifo_full), .empty(fifo_empty)
  );

  // idle timeout for a partly filled queue
  assign to_lim  = TO_W'(timeout_ticks(DATA_W, cfg_par_en, cfg_two_stop));
  assign to_run  = (rx_count != '0) && (rx_count < cfg_trig);
  assign to_fire = to_run & ~fifo_wr & ~fifo_pop & tick16 & (to_cnt == to_lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) to_cnt <= '0;
    else if (!to_run || fifo_wr || fifo_pop) to_cnt <= '0;
    else if (tick16 && to_cnt != to_lim) to_cnt <= to_cnt + 1'b1;
  end

  always_comb begin
    set_v           = '0;
    set_v[FL_READY] = to_fire;
    set_v[FL_FULL]  = (rx_count >= cfg_trig);
    set_v[FL_BRK]   = ev_done & ev_brk;
    set_v[FL_ERR]   = (ev_done & (ev_fer | ev_per)) | overrun;
    clr_v           = stat_wr ? (armed & ~stat_wdata) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      armed <= '0;
    end else begin
      flags <= (flags & ~clr_v) | set_v;
      armed <= stat_rd ? flags : (armed & ~clr_v);
    end
  end

  assign stat_flags = flags;
  assign irq_rx     = rie & (flags[FL_FULL] | flags[FL_READY]);
  assign irq_err    = rie & flags[FL_ERR];
  assign irq_brk    = rie & flags[FL_BRK];
endmodule

// File: rtl/urx_checks.sv
module urx_checks #(
  parameter int CNT_W = 5,
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rie,
  input logic [CNT_W-1:0] cfg_trig,
  input logic             irq_rx,
  input logic             irq_err,
  input logic             irq_brk,
  input logic [3:0]       flags,
  input logic [CNT_W-1:0] count,
  input logic             fifo_wr,
  input logic             fifo_pop,
  input logic             ev_done,
  input logic             ev_fer
);
  p_bad_stop_keeps_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && ev_fer && !fifo_pop) |=> count == $past(count));

  p_break_implies_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> flags[3]);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_halt_no_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[3] || flags[2]) |=> !fifo_wr);

  p_full_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= cfg_trig) |=> flags[1]);

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rie |-> !(irq_rx || irq_err || irq_brk));

  p_pop_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop && !fifo_wr) |=> count == $past(count) - CNT_W'(1));
endmodule

bind uart_rx_fifo urx_checks #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rie(rie), .cfg_trig(cfg_trig),
  .irq_rx(irq_rx), .irq_err(irq_err), .irq_brk(irq_brk),
  .flags(stat_flags), .count(rx_count), .fifo_wr(fifo_wr), .fifo_pop(fifo_pop),
  .ev_done(ev_done), .ev_fer(ev_fer)
);

// File: tb/uart_rx_fifo_test.sv
module uart_rx_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 32;  // 16 ticks, one tick every other clock

  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0, rie = 0, rd_en = 0;
  logic [4:0] cfg_trig = 5'd4;
  logic stat_rd = 0, stat_wr = 0;
  logic [3:0] stat_wdata = '0;
  logic [7:0] rd_data;
  logic [4:0] rx_count;
  logic [3:0] stat_flags;
  logic irq_rx, irq_err, irq_brk;
  int checks = 0, errors = 0;

  uart_rx_fifo uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  initial forever @(negedge clk) tick16 = ~tick16;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic pe, input logic po, input logic ts, input int trig);
    @(negedge clk);
    rst_n = 0; rxd = 1; rie = 0; rd_en = 0; stat_rd = 0; stat_wr = 0;
    cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts; cfg_trig = 5'(trig);
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic stop1 = 1, input logic stop2 = 1,
                      input logic flip = 0);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (cfg_par_en) drive_bit((^d) ^ cfg_par_odd ^ flip);
    drive_bit(stop1);
    if (cfg_two_stop) drive_bit(stop2);
    drive_bit(1'b1);
  endtask

  task automatic pop();
    rd_en = 1; @(negedge clk); rd_en = 0; @(negedge clk);
  endtask

  task automatic clear_flags(input logic [3:0] w, input logic do_read = 1);
    if (do_read) begin stat_rd = 1; @(negedge clk); stat_rd = 0; end
    stat_wr = 1; stat_wdata = w; @(negedge clk); stat_wr = 0; @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(0, 0, 0, 4);
    check("R12 reset flags", stat_flags, 0);
    check("R12 reset count", rx_count, 0);
    check("R12 reset irqs", {irq_rx, irq_err, irq_brk}, 0);
  endtask

  task automatic t_basic();
    do_reset(0, 0, 0, 4);
    send(8'hA5);
    check("R2 first char count", rx_count, 1);
    check("R2 lsb first data", rd_data, 8'hA5);
    send(8'h3C);
    check("R2 second char count", rx_count, 2);
    pop();
    check("R12 pop count", rx_count, 1);
    check("R12 pop head", rd_data, 8'h3C);
    check("R2 no error", stat_flags[3], 0);
  endtask

  task automatic t_glitch();
    do_reset(0, 0, 0, 4);
    rxd = 0; repeat (6) @(negedge clk); rxd = 1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    check("R1 glitch no char", rx_count, 0);
    check("R1 glitch no flag", stat_flags, 0);
  endtask

  task automatic t_parity();
    do_reset(1, 0, 0, 8);
    send(8'h07);
    check("R3 even good no error", stat_flags[3], 0);
    send(8'h07, 1, 1, 1);
    check("R3 even bad error", stat_flags[3], 1);
    check("R3 bad parity stored", rx_count, 2);
    send(8'h55);
    check("R7 halted no receive", rx_count, 2);
    clear_flags(4'h0, 0);
    check("R10 write without read keeps", stat_flags[3], 1);
    clear_flags(4'h0);
    check("R10 read then write0 clears", stat_flags[3], 0);
    send(8'h55);
    check("R7 resumes after clear", rx_count, 3);
    pop(); pop();
    check("R3 resumed char", rd_data, 8'h55);
    do_reset(1, 1, 0, 8);
    send(8'h01);
    check("R3 odd good no error", stat_flags[3], 0);
    send(8'h01, 1, 1, 1);
    check("R3 odd bad error", stat_flags[3], 1);
  endtask

  task automatic t_framing();
    do_reset(0, 0, 0, 4);
    send(8'h81, 0);
    check("R4 bad stop error", stat_flags[3], 1);
    check("R4 bad stop discarded", rx_count, 0);
    check("R4 not break", stat_flags[2], 0);
  endtask

  task automatic t_two_stop();
    do_reset(0, 0, 1, 4);
    send(8'h5A, 1, 0);
    check("R4 second stop unchecked", stat_flags[3], 0);
    check("R4 one char", rx_count, 1);
    send(8'h12);
    check("R4 no false start", rx_count, 2);
  endtask

  task automatic t_break();
    do_reset(0, 0, 0, 4);
    rie = 1;
    rxd = 0; repeat (12 * BIT_CLKS) @(negedge clk); drive_bit(1'b1);
    check("R5 break flag", stat_flags[2], 1);
    check("R5 break sets error", stat_flags[3], 1);
    check("R5 break not stored", rx_count, 0);
    check("R11 irq_brk", irq_brk, 1);
    check("R11 irq_err", irq_err, 1);
    rie = 0; @(negedge clk);
    check("R11 gated off", {irq_rx, irq_err, irq_brk}, 0);
  endtask

  task automatic t_full();
    do_reset(0, 0, 0, 4);
    for (int i = 0; i < 4; i++) send(8'(i + 16));
    check("R8 full flag", stat_flags[1], 1);
    check("R11 irq_rx off", irq_rx, 0);
    rie = 1; @(negedge clk);
    check("R11 irq_rx on", irq_rx, 1);
    clear_flags(4'h0);
    check("R8 stays while at trigger", stat_flags[1], 1);
    pop();
    clear_flags(4'h0);
    check("R8 clears below trigger", stat_flags[1], 0);
  endtask

  task automatic t_overrun();
    do_reset(0, 0, 0, 16);
    for (int i = 0; i < 16; i++) send(8'(i + 1));
    check("R6 queue filled", rx_count, 16);
    check("R6 no error yet", stat_flags[3], 0);
    send(8'hEE);
    check("R6 overrun error", stat_flags[3], 1);
    check("R6 count kept", rx_count, 16);
    check("R6 head kept", rd_data, 1);
  endtask

  task automatic t_timeout();
    do_reset(0, 0, 0, 4);
    send(8'h99);
    repeat (200 * 2) @(negedge clk);
    check("R9 not yet ready", stat_flags[0], 0);
    repeat (60 * 2) @(negedge clk);
    check("R9 ready after timeout", stat_flags[0], 1);
    rie = 1; @(negedge clk);
    check("R11 irq_rx from ready", irq_rx, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1 (run finished)");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_glitch();
    t_parity();
    t_framing();
    t_two_stop();
    t_break();
    t_full();
    t_overrun();
    t_timeout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule